// File: doc/BRIEF.md
# Multi-Chain Configuration Data Serializer

This block turns a stream of 16-bit configuration words into bit groups on an 8-line data bus, paced by a configuration clock (DCLK) that it generates itself. A single stream can be spread across 1, 2, 4 or 8 serial target chains at once, with one data line per chain. A byte-parallel mode feeds one target 8 bits per DCLK cycle. Each word is cut into groups of n bits, least significant group first. Bit k of a group goes out on data line k. Lines the current width does not use stay low.

An upstream sequencer offers words with a valid/ready handshake and flags the final word of a transfer. Width and DCLK divider are taken from `mode_sel` and `dclk_div` when the first word of a transfer is accepted in the idle state. They stay fixed until the flagged last word has been sent. Data moves at DCLK falling edges and is stable across each rising edge, where the target samples. If no word is waiting when a word's last group finishes, DCLK parks low.

Control is a four-state machine:
- IDLE: no transfer is open.
- LOW: DCLK is low and the current group is on the bus.
- HIGH: DCLK is high.
- WAIT: a transfer is open but starved, so DCLK is low and the bus is zero.

The transitions are:
- IDLE to LOW when a word is accepted. Width and divider are latched here.
- LOW to HIGH when the half-period ends.
- HIGH to LOW when the half-period ends and groups remain. The word is shifted.
- HIGH to LOW when the last group ends and a new word is accepted in the same cycle.
- HIGH to WAIT when the last group ends with no word offered and the word was not flagged last.
- HIGH to IDLE when the last group of a flagged word ends.
- WAIT to LOW when a word is accepted.

Top module: `cfgser_top`

## Requirements
- R1: After reset, `dclk` is low, `data_out` is all zero and `word_ready` is high.
- R2: With mode code 0, each word leaves on `data_out[0]` one bit per DCLK cycle, least significant bit first, for 16 DCLK cycles.
- R3: With mode codes 1, 2 and 3, n = 2, 4 and 8 bits are presented per DCLK cycle. Bit k of each group is on `data_out[k]`. Groups go least significant first, with 16/n DCLK cycles per word.
- R4: With mode code 4 (byte parallel), `data_out[7:0]` carries the low byte in the first DCLK cycle and the high byte in the second.
- R5: Data lines at or above the active width are driven low at all times. Mode codes 5, 6 and 7 behave as code 0.
- R6: `data_out` changes only while `dclk` is low, so it is stable for the whole high phase and at each rising edge.
- R7: The DCLK high and low phases each last `dclk_div`+1 system clocks. A value of 0 gives DCLK at half the system clock rate.
- R8: When a word's last group has finished and no word is offered, `dclk` stays low and `data_out` is zero until a word arrives.
- R9: `mode_sel` and `dclk_div` are sampled only when a word is accepted from IDLE. Changes during an open transfer have no effect on the width or period until the transfer ends.
- R10: A word offered before the previous word's last group ends is accepted at that group's falling edge. The DCLK period runs on without a gap across the word boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Upstream offers a word |
| word_data | input | 16 | Configuration word |
| word_last | input | 1 | Offered word closes the transfer |
| word_ready | output | 1 | Word accepted this cycle when valid is also high |
| mode_sel | input | 3 | Width code: 0=x1, 1=x2, 2=x4, 3=x8, 4=byte, 5..7 as x1 |
| dclk_div | input | 4 | DCLK half period minus one, in system clocks |
| dclk | output | 1 | Configuration clock to the targets |
| data_out | output | 8 | Configuration data lines |

## Verification
The same cycle can carry both the falling DCLK edge of a word's final group and the acceptance of the next word, which reloads the shifter and the divider together. The bench provokes this by holding the next word valid before the current word ends, with every width and several divider settings. It judges the result by checking that every rising-edge interval, including the one across the word boundary, equals 2×(`dclk_div`+1) and that the captured groups continue in order. A width and divider change is also applied in the cycle right after a word is accepted inside an open transfer. The bench checks that the following word keeps the old grouping and period.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2,
        S_WAIT = 2'd3
    } ser_state_e;

    // log2 of the active lane count for a width code; reserved codes act as x1
    function automatic logic [1:0] lanes_log2(input logic [2:0] code);
        logic [1:0] r;
        unique case (code)
            3'd1:    r = 2'd1;
            3'd2:    r = 2'd2;
            3'd3:    r = 2'd3;
            3'd4:    r = 2'd3;
            default: r = 2'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfgser_divider.sv
module cfgser_divider #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= div_val;
        end else if (run) begin
            cnt_q <= (cnt_q == '0) ? div_val : cnt_q - 1'b1;
        end
    end

    assign tick = run && (cnt_q == '0);

    // R7: a running phase never exceeds the programmed half period
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= div_val));

endmodule

// File: rtl/cfgser_shifter.sv
module cfgser_shifter #(
    parameter int WORD_W = 16,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              shift,
    input  logic [1:0]        lg,
    input  logic              drive,
    output logic [BUS_W-1:0]  bus_out
);
    localparam int CNT_W = $clog2(BUS_W) + 1;

    logic [WORD_W-1:0] sh_q;
    logic [CNT_W-1:0]  lanes;

    assign lanes = CNT_W'(1) << lg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= word_in;
        end else if (shift) begin
            sh_q <= sh_q >> lanes;
        end
    end

    // one gate per line: live only when inside the active width
    for (genvar b = 0; b < BUS_W; b++) begin : g_lane
        logic lane_on;
        assign lane_on    = (CNT_W'(b) < lanes);
        assign bus_out[b] = drive & lane_on & sh_q[b];
    end

endmodule

// File: rtl/cfgser_ctrl.sv
module cfgser_ctrl
    import cfgser_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_valid,
    input  logic             word_last,
    input  logic [2:0]       mode_in,
    input  logic [DIV_W-1:0] div_in,
    input  logic             tick,
    output logic             word_ready,
    output logic             take,
    output logic             run,
    output logic             shift,
    output logic             drive,
    output logic             dclk,
    output logic [1:0]       lg_eff,
    output logic [DIV_W-1:0] div_eff
);
    localparam int GRP_W = $clog2(WORD_W) + 1;

    ser_state_e       state_q, state_d;
    logic [1:0]       lg_q;
    logic [DIV_W-1:0] div_q;
    logic [GRP_W-1:0] grp_left_q;
    logic             last_q;
    logic             last_grp;

    assign last_grp = (grp_left_q == GRP_W'(1));
    assign lg_eff   = (state_q == S_IDLE) ? lanes_log2(mode_in) : lg_q;
    assign div_eff  = (state_q == S_IDLE) ? div_in : div_q;
    assign take     = word_valid && word_ready;

    // next state and handshake
    always_comb begin
        state_d    = state_q;
        word_ready = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                word_ready = 1'b1;
                if (word_valid) state_d = S_LOW;
            end
            S_LOW: begin
                if (tick) state_d = S_HIGH;
            end
            S_HIGH: begin
                if (tick) begin
                    if (!last_grp) begin
                        state_d = S_LOW;
                    end else if (last_q) begin
                        state_d = S_IDLE;
                    end else begin
                        word_ready = 1'b1;
                        state_d    = word_valid ? S_LOW : S_WAIT;
                    end
                end
            end
            S_WAIT: begin
                word_ready = 1'b1;
                if (word_valid) state_d = S_LOW;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register and per-transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            lg_q       <= '0;
            div_q      <= '0;
            grp_left_q <= '0;
            last_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) begin
                grp_left_q <= GRP_W'(WORD_W >> lg_eff);
                last_q     <= word_last;
                if (state_q == S_IDLE) begin
                    lg_q  <= lanes_log2(mode_in);
                    div_q <= div_in;
                end
            end else if (shift) begin
                grp_left_q <= grp_left_q - 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        dclk  = 1'b0;
        drive = 1'b0;
        shift = 1'b0;
        unique case (state_q)
            S_LOW:  drive = 1'b1;
            S_HIGH: begin
                dclk  = 1'b1;
                drive = 1'b1;
                shift = tick && !last_grp;
            end
            default: ;
        endcase
    end

    assign run = drive;

    assert_ctx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && $past(state_q) != S_IDLE) |-> ($stable(lg_q) && $stable(div_q)));

    assert_groups_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOW || state_q == S_HIGH) |-> (grp_left_q != '0));

    assert_rise_from_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk) |-> ($past(state_q) == S_LOW));

endmodule

// File: rtl/cfgser_top.sv
module cfgser_top #(
    parameter int WORD_W = 16,
    parameter int BUS_W  = 8,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_last,
    output logic              word_ready,
    input  logic [2:0]        mode_sel,
    input  logic [DIV_W-1:0]  dclk_div,
    output logic              dclk,
    output logic [BUS_W-1:0]  data_out
);
    logic             take, run, shift, drive, tick;
    logic [1:0]       lg_eff;
    logic [DIV_W-1:0] div_eff;

    cfgser_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .word_valid(word_valid), .word_last(word_last),
        .mode_in(mode_sel), .div_in(dclk_div), .tick(tick),
        .word_ready(word_ready), .take(take), .run(run), .shift(shift),
        .drive(drive), .dclk(dclk), .lg_eff(lg_eff), .div_eff(div_eff)
    );

    cfgser_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .load(take), .run(run),
        .div_val(div_eff), .tick(tick)
    );

    cfgser_shifter #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(take), .word_in(word_data),
        .shift(shift), .lg(lg_eff), .drive(drive), .bus_out(data_out)
    );

    assert_unused_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (({{(32-BUS_W){1'b0}}, data_out} >> (32'd1 << lg_eff)) == 32'd0));

    assert_stable_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk && $past(dclk)) |-> $stable(data_out));

    assert_park_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready && !word_valid) |=> (!dclk && data_out == '0));

endmodule

// File: tb/sim_cfgser_top.sv
module sim_cfgser_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = '0;
    logic        word_last = 1'b0;
    logic        word_ready;
    logic [2:0]  mode_sel = '0;
    logic [3:0]  dclk_div = '0;
    logic        dclk;
    logic [7:0]  data_out;

    int checks = 0;
    int errors = 0;

    logic [7:0] cap [0:63];
    int         rt  [0:63];
    int         cap_n = 0;
    int         cyc = 0;
    int         unstable = 0;
    int         gap_hits = 0;
    bit         in_gap = 0;
    logic       prev_dclk = 1'b0;
    logic [7:0] prev_data = '0;

    always #4 clk = ~clk;

    cfgser_top u0 (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .word_last(word_last), .word_ready(word_ready), .mode_sel(mode_sel),
        .dclk_div(dclk_div), .dclk(dclk), .data_out(data_out)
    );

    // capture on each rising DCLK, sampled mid-cycle
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (dclk && !prev_dclk && cap_n < 64) begin
            cap[cap_n] <= data_out;
            rt[cap_n]  <= cyc;
            cap_n      <= cap_n + 1;
        end
        if (dclk && prev_dclk && data_out != prev_data) unstable <= unstable + 1;
        if (in_gap && (dclk || data_out != 8'h00)) gap_hits <= gap_hits + 1;
        prev_dclk <= dclk;
        prev_data <= data_out;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put_word(input logic [15:0] w, input logic last);
        @(negedge clk);
        word_valid = 1'b1; word_data = w; word_last = last;
        #1;
        while (!word_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        word_valid = 1'b0;
    endtask

    task automatic wait_caps(input int n);
        for (int i = 0; i < 5000 && cap_n < n; i++) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    task automatic clear_caps();
        @(negedge clk);
        cap_n = 0; unstable = 0;
    endtask

    function automatic logic [7:0] grp(input logic [15:0] w, input int n, input int g);
        return 8'((w >> (g * n)) & ((16'd1 << n) - 16'd1));
    endfunction

    task automatic judge(input string req, input logic [15:0] w0, input logic [15:0] w1,
                         input int nwords, input int n, input int div, input int skip_iv);
        int g = 16 / n;
        check(cap_n == nwords * g, req, cap_n, nwords * g);
        for (int i = 0; i < nwords * g && i < cap_n; i++) begin
            logic [7:0] e;
            e = grp((i < g) ? w0 : w1, n, i % g);
            check(cap[i] == e, req, cap[i], e);
        end
        for (int i = 1; i < cap_n; i++) begin
            if (i != skip_iv)
                check(rt[i] - rt[i-1] == 2 * (div + 1), "R7/R10", rt[i] - rt[i-1], 2 * (div + 1));
        end
        check(unstable == 0, "R6", unstable, 0);
    endtask

    task automatic t_reset();
        check(dclk == 1'b0, "R1", dclk, 0);
        check(data_out == 8'h00, "R1", data_out, 0);
        check(word_ready == 1'b1, "R1", word_ready, 1);
    endtask

    task automatic t_pair(input string req, input logic [2:0] code, input int n,
                          input int div, input logic [15:0] w0, input logic [15:0] w1);
        clear_caps();
        mode_sel = code; dclk_div = 4'(div);
        put_word(w0, 1'b0);
        put_word(w1, 1'b1);
        wait_caps(2 * 16 / n);
        judge(req, w0, w1, 2, n, div, -1);
    endtask

    task automatic t_stall();
        clear_caps();
        mode_sel = 3'd1; dclk_div = 4'd0;
        put_word(16'hC3A5, 1'b0);
        wait_caps(8);
        in_gap = 1;
        repeat (20) @(negedge clk);
        in_gap = 0;
        check(gap_hits == 0, "R8", gap_hits, 0);
        check(dclk == 1'b0 && data_out == 8'h00, "R8", {dclk, data_out}, 0);
        put_word(16'h0FF1, 1'b1);
        wait_caps(16);
        judge("R8", 16'hC3A5, 16'h0FF1, 2, 2, 0, 8);
    endtask

    task automatic t_mode_change();
        clear_caps();
        mode_sel = 3'd2; dclk_div = 4'd1;
        put_word(16'h9B2E, 1'b0);
        mode_sel = 3'd0; dclk_div = 4'd5;
        put_word(16'h4D71, 1'b1);
        wait_caps(8);
        judge("R9", 16'h9B2E, 16'h4D71, 2, 4, 1, -1);
        clear_caps();
        put_word(16'hA00F, 1'b1);
        wait_caps(16);
        judge("R9", 16'hA00F, 16'h0000, 1, 1, 5, -1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pair("R2", 3'd0, 1, 0, 16'hB38D, 16'h6E19);
        t_pair("R3", 3'd1, 2, 1, 16'h5AC3, 16'h2F70);
        t_pair("R3", 3'd2, 4, 3, 16'h1234, 16'hFEDC);
        t_pair("R3", 3'd3, 8, 0, 16'h81E7, 16'h3C55);
        t_pair("R4", 3'd4, 8, 2, 16'hA5F0, 16'h0F5A);
        t_pair("R5", 3'd6, 1, 0, 16'hFFFF, 16'h8001);
        t_stall();
        t_mode_change();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule